// File: doc/BRIEF.md
# Dual-Core Sleep Entry Sequencer

This block decides when a two-core device drops into its low-power sleep state and walks it back out. Software arms sleep by setting a select bit in a small control register. Each core reports two levels: whether it is held in reset and whether it has executed its wait instruction. Sleep starts once the select bit is set and every core that is out of reset reports wait. A core held in reset is left out of that test. If every core is held in reset, sleep never starts.

While asleep, the sequencer owns the device. It asks for the PLL to be gated off. It also gates the main crystal oscillator when a second configuration bit asks for that. A wake request from the wake-up logic ends sleep. If the oscillator had been powered down, it is re-enabled first and a programmable stabilization count runs before a one-cycle wake-done pulse is issued. If the oscillator stayed on, the count is skipped. The select bit clears itself on the way out. A wake request that arrives while the cores are still gathering their waits cancels the armed entry.

The block carries no data stream, so there is no valid/ready handshake. Every pin is a plain control or status level, apart from the wake-done pulse.

Top module: `slp_seq_top`

## Requirements
- R1: After reset, sleep_sel, sleep_active, pll_off, osc_off and wake_done are all 0.
- R2: A cycle with cfg_we high loads cfg_sleep_d into sleep_sel and cfg_osc_pd_d into the oscillator power-down setting, visible one cycle later. While sleep_sel is 0, wait reports from the cores never start sleep.
- R3: With sleep_sel at 1 and wake_req low, sleep_active rises one cycle after every core with core_in_rst[i]=0 has core_waiting[i]=1. The core_waiting bit of a core held in reset is ignored, and a single live core waiting is enough.
- R4: When every core is held in reset, sleep is never entered.
- R5: While sleep_active is 1 before the wake request, pll_off is 1 and osc_off equals the power-down setting captured at entry.
- R6: Register writes are ignored from sleep entry until the sequencer has returned to the running state. A write of sleep_sel=0 during sleep leaves sleep_sel at 1.
- R7: A wake_req while running with sleep_sel set clears sleep_sel and blocks entry, even when the entry condition holds in the same cycle.
- R8: With the oscillator left running, the cycle after wake_req is seen in sleep shows wake_done=1, sleep_active=0 and pll_off=0.
- R9: With the oscillator powered down, osc_off drops the cycle after wake_req while sleep_active stays 1 for N cycles. N is stab_cycles, and a value of 0 acts as 1. wake_done follows those N cycles.
- R10: sleep_sel reads 0 from the first cycle after the wake request is taken.
- R11: wake_done lasts exactly one cycle. Afterwards sleep is not re-entered until sleep_sel is written to 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sleep_d | input | 1 | Sleep select value to write |
| cfg_osc_pd_d | input | 1 | Oscillator power-down setting to write |
| stab_cycles | input | CNT_W | Oscillator stabilization count on wake |
| core_in_rst | input | NCORE | Per-core held-in-reset level |
| core_waiting | input | NCORE | Per-core wait-executed level |
| wake_req | input | 1 | Wake request from wake-up logic |
| sleep_sel | output | 1 | Current sleep select bit |
| sleep_active | output | 1 | Device is in sleep or its wake stabilization |
| pll_off | output | 1 | Request to gate the PLL |
| osc_off | output | 1 | Request to power down the main oscillator |
| wake_done | output | 1 | One-cycle pulse when wake-up completes |

## Verification
Two functions can fall in the same cycle: the entry decision and the cancel by wake request. The bench arms sleep_sel, then raises the last missing core wait and wake_req on the same edge. It judges the result by sleep_active staying 0 and sleep_sel reading 0 one cycle later. A second pairing is the automatic clear of sleep_sel and the ignored write during sleep. The bench drives a write of 0 while asleep and checks that sleep_sel still reads 1. A scoreboard compares the stabilization length of each wake episode with the value it predicts.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STAB  = 2'd2,
    ST_DONE  = 2'd3
  } slp_state_e;
endpackage

// File: rtl/slp_ctrl_reg.sv
module slp_ctrl_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic sel_d,
  input  logic pd_d,
  input  logic wr_open,
  input  logic clr,
  output logic sel_q,
  output logic pd_q
);
  logic wr_ok;
  assign wr_ok = we && wr_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      pd_q  <= 1'b0;
    end else begin
      if (clr)        sel_q <= 1'b0;
      else if (wr_ok) sel_q <= sel_d;
      if (wr_ok)      pd_q  <= pd_d;
    end
  end

  // R10: automatic clear takes effect on the next cycle
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sel_q);
  // R6: setting frozen while writes are closed
  a_r6_locked_pd: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_open |=> $stable(pd_q));
  a_r6_locked_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_open && !clr) |=> $stable(sel_q));
endmodule

// File: rtl/slp_gather.sv
module slp_gather #(
  parameter int NCORE = 2
) (
  input  logic [NCORE-1:0] core_in_rst,
  input  logic [NCORE-1:0] core_waiting,
  output logic             ready
);
  logic [NCORE-1:0] core_ok;
  logic [NCORE-1:0] core_live;

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    assign core_live[i] = !core_in_rst[i];
    assign core_ok[i]   = core_in_rst[i] || core_waiting[i];
  end

  assign ready = (&core_ok) && (|core_live);
endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
  import slp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_q,
  input  logic             pd_q,
  input  logic             ready,
  input  logic             wake_req,
  input  logic [CNT_W-1:0] stab_n,
  output logic             sleep_active,
  output logic             pll_off,
  output logic             osc_off,
  output logic             wake_done,
  output logic             clr,
  output logic             wr_open
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  slp_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic             osc_lat;
  logic             entry;
  logic             cancel;
  logic             leave;

  assign entry  = (st == ST_RUN) && sel_q && ready && !wake_req;
  assign cancel = (st == ST_RUN) && sel_q && wake_req;
  assign leave  = (st == ST_SLEEP) && wake_req;
  assign clr    = cancel || leave;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_RUN;
      cnt     <= '0;
      osc_lat <= 1'b0;
    end else begin
      unique case (st)
        ST_RUN: begin
          if (entry) begin
            st      <= ST_SLEEP;
            osc_lat <= pd_q;
          end
        end
        ST_SLEEP: begin
          if (wake_req) begin
            if (osc_lat) begin
              st  <= ST_STAB;
              cnt <= (stab_n == '0) ? CNT_ONE : stab_n;
            end else begin
              st <= ST_DONE;
            end
          end
        end
        ST_STAB: begin
          if (cnt <= CNT_ONE) st <= ST_DONE;
          else                cnt <= cnt - CNT_ONE;
        end
        ST_DONE: begin
          st      <= ST_RUN;
          osc_lat <= 1'b0;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign sleep_active = (st == ST_SLEEP) || (st == ST_STAB);
  assign pll_off      = sleep_active;
  assign osc_off      = (st == ST_SLEEP) && osc_lat;
  assign wake_done    = (st == ST_DONE);
  assign wr_open      = (st == ST_RUN);

  // R3: entry needs the armed bit and the gathered waits
  a_r3_entry_gated: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> ($past(sel_q) && $past(ready)));
  // R7: wake request while running blocks entry
  a_r7_wake_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_RUN) && wake_req) |=> !sleep_active);
  // R11: single-cycle completion pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |=> (!wake_done && !sleep_active));
  // R5: oscillator gating only if configured
  a_r5_osc_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off |-> pd_q);
  // R9: oscillator running during stabilization
  a_r9_stab_osc_on: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STAB) |-> (!osc_off && pll_off));
endmodule

// File: rtl/slp_seq_top.sv
module slp_seq_top #(
  parameter int NCORE = 2,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sleep_d,
  input  logic             cfg_osc_pd_d,
  input  logic [CNT_W-1:0] stab_cycles,
  input  logic [NCORE-1:0] core_in_rst,
  input  logic [NCORE-1:0] core_waiting,
  input  logic             wake_req,
  output logic             sleep_sel,
  output logic             sleep_active,
  output logic             pll_off,
  output logic             osc_off,
  output logic             wake_done
);
  logic pd_q;
  logic ready;
  logic clr;
  logic wr_open;

  slp_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .sel_d   (cfg_sleep_d),
    .pd_d    (cfg_osc_pd_d),
    .wr_open (wr_open),
    .clr     (clr),
    .sel_q   (sleep_sel),
    .pd_q    (pd_q)
  );

  slp_gather #(.NCORE(NCORE)) u_gather (
    .core_in_rst  (core_in_rst),
    .core_waiting (core_waiting),
    .ready        (ready)
  );

  slp_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .sel_q        (sleep_sel),
    .pd_q         (pd_q),
    .ready        (ready),
    .wake_req     (wake_req),
    .stab_n       (stab_cycles),
    .sleep_active (sleep_active),
    .pll_off      (pll_off),
    .osc_off      (osc_off),
    .wake_done    (wake_done),
    .clr          (clr),
    .wr_open      (wr_open)
  );

  // R4: no entry when all cores were held in reset
  a_r4_all_rst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_active) |-> !$past(&core_in_rst));
endmodule

// File: tb/slp_seq_top_bench.sv
`timescale 1ns/1ps
module slp_seq_top_bench;
  localparam int NCORE = 2;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_we, cfg_sleep_d, cfg_osc_pd_d;
  logic [CNT_W-1:0] stab_cycles;
  logic [NCORE-1:0] core_in_rst, core_waiting;
  logic             wake_req;
  logic             sleep_sel, sleep_active, pll_off, osc_off, wake_done;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  slp_seq_top #(.NCORE(NCORE), .CNT_W(CNT_W)) u_slp_seq_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sleep_d(cfg_sleep_d),
    .cfg_osc_pd_d(cfg_osc_pd_d), .stab_cycles(stab_cycles),
    .core_in_rst(core_in_rst), .core_waiting(core_waiting),
    .wake_req(wake_req), .sleep_sel(sleep_sel), .sleep_active(sleep_active),
    .pll_off(pll_off), .osc_off(osc_off), .wake_done(wake_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic pd);
    cfg_we = 1'b1; cfg_sleep_d = sel; cfg_osc_pd_d = pd;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Monitor: counts stabilization cycles of each wake episode.
  int  stab_seen = 0;
  bit  woke = 0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        if (woke && sleep_active) stab_seen++;
        if (wake_done) begin
          checks++;
          if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9: actual unexpected wake_done expected none");
          end else begin
            int e;
            e = exp_q.pop_front();
            if (stab_seen != e) begin
              errors++;
              $display("FAIL R9: actual %0d stab cycles expected %0d", stab_seen, e);
            end
          end
          woke = 0; stab_seen = 0;
        end
        if (sleep_active && wake_req && !woke) woke = 1;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_sleep_d = 0; cfg_osc_pd_d = 0;
    stab_cycles = '0; core_in_rst = '0; core_waiting = '0; wake_req = 0;
    cyc(3);
    rst_n = 1'b1;
    cyc(1); #1;
    chk("R1 sleep_sel", sleep_sel, 0);
    chk("R1 sleep_active", sleep_active, 0);
    chk("R1 pll_off", pll_off, 0);
    chk("R1 osc_off", osc_off, 0);
    chk("R1 wake_done", wake_done, 0);

    // R2: waits without the bit
    wr(1'b0, 1'b0);
    core_waiting = 2'b11;
    cyc(3); #1;
    chk("R2 no entry with bit clear", sleep_active, 0);
    core_waiting = 2'b00;

    // R3/R5/R6/R8/R10: episode with oscillator running
    wr(1'b1, 1'b0); #1;
    chk("R2 sleep_sel written", sleep_sel, 1);
    core_waiting = 2'b11;
    cyc(1); #1;
    chk("R3 entry", sleep_active, 1);
    chk("R5 pll_off", pll_off, 1);
    chk("R5 osc_off kept on", osc_off, 0);
    wr(1'b0, 1'b0); #1;
    chk("R6 write ignored in sleep", sleep_sel, 1);
    exp_q.push_back(0);
    wake_req = 1'b1;
    cyc(1); wake_req = 1'b0; core_waiting = 2'b00; #1;
    chk("R8 wake_done", wake_done, 1);
    chk("R8 sleep_active low", sleep_active, 0);
    chk("R8 pll_off low", pll_off, 0);
    chk("R10 sleep_sel cleared", sleep_sel, 0);
    cyc(1); #1;
    chk("R11 pulse one cycle", wake_done, 0);
    core_waiting = 2'b11;
    cyc(3); #1;
    chk("R11 no re-entry without bit", sleep_active, 0);
    core_waiting = 2'b00;

    // R9: oscillator powered down, N=4
    stab_cycles = 8'd4;
    wr(1'b1, 1'b1);
    core_waiting = 2'b11;
    cyc(1); #1;
    chk("R5 osc_off gated", osc_off, 1);
    exp_q.push_back(4);
    wake_req = 1'b1;
    cyc(1); wake_req = 1'b0; #1;
    chk("R9 osc re-enabled", osc_off, 0);
    chk("R9 still active", sleep_active, 1);
    chk("R10 sleep_sel cleared early", sleep_sel, 0);
    cyc(3); #1;
    chk("R9 last stab cycle", sleep_active, 1);
    chk("R9 no early done", wake_done, 0);
    cyc(1); #1;
    chk("R9 done after N", wake_done, 1);
    core_waiting = 2'b00;
    cyc(1);

    // R9: N=0 acts as 1
    stab_cycles = 8'd0;
    wr(1'b1, 1'b1);
    core_waiting = 2'b11;
    cyc(1);
    exp_q.push_back(1);
    wake_req = 1'b1;
    cyc(1); wake_req = 1'b0; #1;
    chk("R9 zero count active", sleep_active, 1);
    cyc(1); #1;
    chk("R9 zero count done", wake_done, 1);
    core_waiting = 2'b00;
    cyc(1);

    // R3: core 1 held in reset, core 0 alone waits
    core_in_rst = 2'b10; core_waiting = 2'b01;
    wr(1'b1, 1'b0);
    cyc(1); #1;
    chk("R3 reset core excluded", sleep_active, 1);
    exp_q.push_back(0);
    wake_req = 1'b1;
    cyc(1); wake_req = 1'b0; core_waiting = 2'b00; #1;
    chk("R8 done single core", wake_done, 1);
    cyc(1);

    // R4: all cores held in reset
    core_in_rst = 2'b11; core_waiting = 2'b11;
    wr(1'b1, 1'b0);
    cyc(3); #1;
    chk("R4 no entry all reset", sleep_active, 0);

    // R7: cancel while gathering
    core_in_rst = 2'b00; core_waiting = 2'b01;
    cyc(2); #1;
    chk("R3 waits incomplete", sleep_active, 0);
    wake_req = 1'b1;
    cyc(1); wake_req = 1'b0; #1;
    chk("R7 cancel clears bit", sleep_sel, 0);
    core_waiting = 2'b11;
    cyc(2); #1;
    chk("R7 no entry after cancel", sleep_active, 0);
    core_waiting = 2'b00;

    // R7: cancel coinciding with entry condition
    wr(1'b1, 1'b0);
    core_waiting = 2'b11; wake_req = 1'b1;
    cyc(1); wake_req = 1'b0; #1;
    chk("R7 coincident no entry", sleep_active, 0);
    chk("R7 coincident bit cleared", sleep_sel, 0);
    cyc(2); #1;
    chk("R7 stays running", sleep_active, 0);

    chk("R9 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    finish_run();
  end
endmodule